// File: doc/BRIEF.md
# Cipher Engine Command Word Dispatcher

This block sits between a host and a cipher engine. The host writes 32-bit command words into a five-entry queue. The block decodes each word and turns it into actions on three neighbours: a block-cipher datapath, a memory-move unit, and a key-table loader. The cipher datapath and the memory-move unit are each reached through a request/done handshake. The key-table loader receives a one-cycle strobe. Two commands take an operand word. The block captures that second word and does not decode it as a new command.

The opcode sits in bits [31:26] of a command word. A command that needs a unit which is still working stays at the head of the queue until that unit is free. At most one word leaves the queue per cycle. Three status bits report the engine activity, the queue state and the memory-move activity. Three sticky interrupt flags record completion, an unknown opcode and a queue overflow. The host clears a flag by writing one to its bit, and a single interrupt line is the OR of the flags.

Top module: `cmdq_parser`

## Requirements
- R1: During reset and right after it, the queue is empty, `status` reads 3'b010, `int_flags` and `irq` are 0, and `eng_req`, `mv_req` and `tbl_load` are 0.
- R2: The queue holds up to 5 words in arrival order. A word written while 5 words are held is dropped, even if a word leaves in the same cycle. The drop sets sticky flag `int_flags[2]`.
- R3: Opcode 0x10 takes the next queued word as an operand. That word, whatever its bits, appears on `src_addr` and is not decoded.
- R4: Opcode 0x0E raises `eng_req` and `status[0]`. It sets `eng_blocks` to the value of bits [BLK_W-1:0] plus one, so 0 means one block. Both stay high until `eng_done`. Another 0x0E waits at the head while the engine is busy.
- R5: Opcode 0x22 latches its direction from bit 25 (1 = internal RAM to external) onto `mv_to_ext` and its word count from bits [23:12] onto `mv_words`. It takes the next word as the external address on `mv_addr`. At that point `mv_req` and `status[2]` rise and stay high until `mv_done`. A second 0x22 waits while the mover is busy.
- R6: Opcode 0x15 waits while the mover is busy and then gives a one-cycle `tbl_load`. It sets `tbl_sel` from bits [25:24], `tbl_internal` from bit 23, `tbl_key` from bit 20 and `tbl_slot` from bits [19:17].
- R7: Opcode 0x11 waits until both the engine and the mover are idle, then retires and sets `int_flags[0]`.
- R8: Any other opcode is discarded and sets `int_flags[1]`. The words after it are still processed.
- R9: A one on `int_clr[i]` clears `int_flags[i]`. A flag set in the same cycle stays set. `irq` is the OR of the three flags.
- R10: A word written at clock edge t can leave the queue at edge t+1. `status[1]` reports an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 32 | Command word |
| int_clr | input | 3 | Write-one-to-clear for the interrupt flags |
| eng_req | output | 1 | Cipher datapath request, held until done |
| eng_blocks | output | BLK_W+1 | Number of 16-byte blocks to process |
| eng_done | input | 1 | Cipher datapath finished |
| src_addr | output | 32 | Input buffer address from the transfer setup command |
| mv_req | output | 1 | Memory-move request, held until done |
| mv_to_ext | output | 1 | Move direction, 1 = internal RAM to external memory |
| mv_words | output | 12 | Move length in 32-bit words |
| mv_addr | output | 32 | External address of the move |
| mv_done | input | 1 | Memory move finished |
| tbl_load | output | 1 | One-cycle key table load strobe |
| tbl_sel | output | 2 | Table select |
| tbl_internal | output | 1 | Take the table from internal RAM |
| tbl_key | output | 1 | Key table flag |
| tbl_slot | output | 3 | Key slot number |
| status | output | 3 | {mover busy, queue empty, engine busy} |
| int_flags | output | 3 | {overflow, bad opcode, done} sticky flags |
| irq | output | 1 | Interrupt line |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a host write against the dispatcher popping a word. To provoke it, the bench fills the queue while a blocked start command waits at the head. It then writes one more word in exactly the cycle the engine frees and the head leaves. That word must be dropped and must raise the overflow flag. The second pair is an interrupt being raised against the host clearing it. The bench holds `int_clr[0]` high across the cycle in which a transfer-complete command retires, and the done flag must survive the clear. In both cases a behavioural queue model in the bench predicts every output on every cycle.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
   localparam int WORD_W  = 32;
   localparam int OPC_LSB = 26;
   localparam int NUM_INT = 3;
   localparam int INT_DONE  = 0;
   localparam int INT_BADOP = 1;
   localparam int INT_OVF   = 2;

   typedef enum logic [5:0] {
      OP_BLKGO    = 6'h0E,
      OP_XFER_SET = 6'h10,
      OP_XFER_END = 6'h11,
      OP_TABLE    = 6'h15,
      OP_MOVE     = 6'h22
   } op_e;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
   parameter int DEPTH = 5,
   parameter int W     = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_req,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         drop
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nxt, rp_nxt;
   logic [CW-1:0] cnt;
   logic          full, accept;

   generate
      if (POW2) begin : g_pow2
         assign wp_nxt = wp + PW'(1);
         assign rp_nxt = rp + PW'(1);
      end else begin : g_wrap
         assign wp_nxt = (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
         assign rp_nxt = (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      end
   endgenerate

   assign full   = (cnt == CW'(DEPTH));
   assign empty  = (cnt == '0);
   assign accept = push_req && !full;
   assign drop   = push_req && full;
   assign head   = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (accept) wp <= wp_nxt;
         if (pop)    rp <= rp_nxt;
         cnt <= cnt + CW'(accept) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (accept) mem[wp] <= push_data;
   end
endmodule

// File: rtl/cmdq_irq.sv
module cmdq_irq #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic f;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) f <= 1'b0;
         else        f <= set[i] | (f & ~clr[i]);
      end
      assign flags[i] = f;
   end
   assign irq = |flags;
endmodule

// File: rtl/cmdq_parser.sv
module cmdq_parser
   import cmdq_pkg::*;
#(
   parameter int DEPTH = 5,
   parameter int BLK_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [31:0]      cmd_data,
   input  logic [2:0]       int_clr,
   output logic             eng_req,
   output logic [BLK_W:0]   eng_blocks,
   input  logic             eng_done,
   output logic [31:0]      src_addr,
   output logic             mv_req,
   output logic             mv_to_ext,
   output logic [11:0]      mv_words,
   output logic [31:0]      mv_addr,
   input  logic             mv_done,
   output logic             tbl_load,
   output logic [1:0]       tbl_sel,
   output logic             tbl_internal,
   output logic             tbl_key,
   output logic [2:0]       tbl_slot,
   output logic [2:0]       status,
   output logic [2:0]       int_flags,
   output logic             irq
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cmdq_parser: DEPTH must be at least 2");
      end
      if (BLK_W < 1 || BLK_W > OPC_LSB) begin : g_bad_blk
         $error("cmdq_parser: BLK_W must lie in 1..26");
      end
   endgenerate

   logic [WORD_W-1:0] hd;
   logic              q_empty, q_drop, pop;
   logic              eng_busy, dma_busy;
   logic              want_opnd, opnd_move;
   logic              do_start, do_end, do_tbl, do_mvop, do_setop, do_opnd, bad;
   logic [NUM_INT-1:0] int_set;
   logic [5:0]        hd_opc;

   cmdq_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push_req(cmd_wr), .push_data(cmd_data), .pop(pop),
      .head(hd), .empty(q_empty), .drop(q_drop)
   );

   assign hd_opc = hd[WORD_W-1:OPC_LSB];

   always_comb begin
      pop = 1'b0; do_start = 1'b0; do_end = 1'b0; do_tbl = 1'b0;
      do_mvop = 1'b0; do_setop = 1'b0; do_opnd = 1'b0; bad = 1'b0;
      if (!q_empty) begin
         if (want_opnd) begin
            pop = 1'b1; do_opnd = 1'b1;
         end else begin
            case (hd_opc)
               OP_XFER_SET: begin pop = 1'b1; do_setop = 1'b1; end
               OP_BLKGO:    if (!eng_busy) begin pop = 1'b1; do_start = 1'b1; end
               OP_XFER_END: if (!eng_busy && !dma_busy) begin pop = 1'b1; do_end = 1'b1; end
               OP_TABLE:    if (!dma_busy) begin pop = 1'b1; do_tbl = 1'b1; end
               OP_MOVE:     if (!dma_busy) begin pop = 1'b1; do_mvop = 1'b1; end
               default:     begin pop = 1'b1; bad = 1'b1; end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         want_opnd    <= 1'b0;
         opnd_move    <= 1'b0;
         eng_busy     <= 1'b0;
         dma_busy     <= 1'b0;
         eng_blocks   <= '0;
         src_addr     <= '0;
         mv_to_ext    <= 1'b0;
         mv_words     <= '0;
         mv_addr      <= '0;
         tbl_load     <= 1'b0;
         tbl_sel      <= '0;
         tbl_internal <= 1'b0;
         tbl_key      <= 1'b0;
         tbl_slot     <= '0;
      end else begin
         tbl_load <= do_tbl;
         if (do_setop || do_mvop) begin
            want_opnd <= 1'b1;
            opnd_move <= do_mvop;
         end else if (do_opnd) begin
            want_opnd <= 1'b0;
         end
         if (do_opnd && !opnd_move) src_addr <= hd;
         if (do_opnd && opnd_move)  mv_addr  <= hd;
         if (do_mvop) begin
            mv_to_ext <= hd[25];
            mv_words  <= hd[23:12];
         end
         if (do_start) eng_blocks <= {1'b0, hd[BLK_W-1:0]} + (BLK_W+1)'(1);
         if (do_tbl) begin
            tbl_sel      <= hd[25:24];
            tbl_internal <= hd[23];
            tbl_key      <= hd[20];
            tbl_slot     <= hd[19:17];
         end
         if (do_start)      eng_busy <= 1'b1;
         else if (eng_done) eng_busy <= 1'b0;
         if (do_opnd && opnd_move) dma_busy <= 1'b1;
         else if (mv_done)         dma_busy <= 1'b0;
      end
   end

   always_comb begin
      int_set            = '0;
      int_set[INT_DONE]  = do_end;
      int_set[INT_BADOP] = bad;
      int_set[INT_OVF]   = q_drop;
   end

   cmdq_irq #(.N(NUM_INT)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(int_set), .clr(int_clr),
      .flags(int_flags), .irq(irq)
   );

   assign eng_req = eng_busy;
   assign mv_req  = dma_busy;
   assign status  = {dma_busy, q_empty, eng_busy};
endmodule

// File: rtl/cmdq_parser_chk.sv
module cmdq_parser_chk #(
   parameter int BLK_W = 12
) (
   input logic           clk,
   input logic           rst_n,
   input logic           eng_req,
   input logic           eng_done,
   input logic [BLK_W:0] eng_blocks,
   input logic           mv_req,
   input logic           mv_done,
   input logic [31:0]    mv_addr,
   input logic [11:0]    mv_words,
   input logic           tbl_load,
   input logic [2:0]     int_flags,
   input logic [2:0]     int_clr
);
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      int_flags[2] && !int_clr[2] |=> int_flags[2]); // R2
   AST_ENG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req && !eng_done |=> eng_req && $stable(eng_blocks)); // R4
   AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mv_req && !mv_done |=> mv_req && $stable(mv_addr) && $stable(mv_words)); // R5
   AST_TBL_MOVER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_load |-> !mv_req); // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_flags[0]) |-> !eng_req && !mv_req); // R7
endmodule

bind cmdq_parser cmdq_parser_chk #(.BLK_W(BLK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_done(eng_done),
   .eng_blocks(eng_blocks), .mv_req(mv_req), .mv_done(mv_done),
   .mv_addr(mv_addr), .mv_words(mv_words), .tbl_load(tbl_load),
   .int_flags(int_flags), .int_clr(int_clr)
);

// File: tb/cmdq_parser_tb_top.sv
`timescale 1ns/1ps
module cmdq_parser_tb_top;
   localparam int BLK_W = 12;
   localparam int DEPTH = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_wr = 1'b0;
   logic [31:0] cmd_data = '0;
   logic [2:0] int_clr = '0;
   logic eng_done = 1'b0, mv_done = 1'b0;
   logic eng_req, mv_req, mv_to_ext, tbl_load, tbl_internal, tbl_key, irq;
   logic [BLK_W:0] eng_blocks;
   logic [31:0] src_addr, mv_addr;
   logic [11:0] mv_words;
   logic [1:0] tbl_sel;
   logic [2:0] tbl_slot, status, int_flags;

   always #2 clk = ~clk;

   cmdq_parser #(.DEPTH(DEPTH), .BLK_W(BLK_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
      .int_clr(int_clr), .eng_req(eng_req), .eng_blocks(eng_blocks),
      .eng_done(eng_done), .src_addr(src_addr), .mv_req(mv_req),
      .mv_to_ext(mv_to_ext), .mv_words(mv_words), .mv_addr(mv_addr),
      .mv_done(mv_done), .tbl_load(tbl_load), .tbl_sel(tbl_sel),
      .tbl_internal(tbl_internal), .tbl_key(tbl_key), .tbl_slot(tbl_slot),
      .status(status), .int_flags(int_flags), .irq(irq)
   );

   int n_chk = 0, n_err = 0;
   bit running = 0;
   int eng_lat = 5, mv_lat = 7, eng_age = 0, mv_age = 0;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   // behavioural reference
   logic [31:0] mq[$];
   bit m_opnd, m_opnd_mv, m_eng, m_dma, m_dir, m_tload, m_tint, m_tkey;
   logic [BLK_W:0] m_blocks;
   logic [31:0] m_src, m_maddr;
   logic [11:0] m_words;
   logic [1:0] m_tsel;
   logic [2:0] m_tslot, m_int;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mq.delete();
         m_opnd = 0; m_opnd_mv = 0; m_eng = 0; m_dma = 0; m_dir = 0; m_tload = 0;
         m_tint = 0; m_tkey = 0; m_blocks = '0; m_src = '0; m_maddr = '0;
         m_words = '0; m_tsel = '0; m_tslot = '0; m_int = '0;
      end else begin
         logic [31:0] h;
         bit popit, st, mvst, ovf;
         logic [2:0] set;
         popit = 0; st = 0; mvst = 0; set = '0; m_tload = 0;
         ovf = cmd_wr && (mq.size() == DEPTH);
         if (mq.size() > 0) begin
            h = mq[0];
            if (m_opnd) begin
               popit = 1; m_opnd = 0;
               if (m_opnd_mv) begin m_maddr = h; mvst = 1; end
               else m_src = h;
            end else begin
               case (h[31:26])
                  6'h10: begin popit = 1; m_opnd = 1; m_opnd_mv = 0; end
                  6'h0E: if (!m_eng) begin
                     popit = 1; st = 1;
                     m_blocks = (BLK_W+1)'(h[BLK_W-1:0]) + 1;
                  end
                  6'h11: if (!m_eng && !m_dma) begin popit = 1; set[0] = 1; end
                  6'h15: if (!m_dma) begin
                     popit = 1; m_tload = 1; m_tsel = h[25:24]; m_tint = h[23];
                     m_tkey = h[20]; m_tslot = h[19:17];
                  end
                  6'h22: if (!m_dma) begin
                     popit = 1; m_opnd = 1; m_opnd_mv = 1;
                     m_dir = h[25]; m_words = h[23:12];
                  end
                  default: begin popit = 1; set[1] = 1; end
               endcase
            end
         end
         if (popit) void'(mq.pop_front());
         if (cmd_wr && !ovf) mq.push_back(cmd_data);
         set[2] = ovf;
         m_eng = st ? 1'b1 : (eng_done ? 1'b0 : m_eng);
         m_dma = mvst ? 1'b1 : (mv_done ? 1'b0 : m_dma);
         m_int = (m_int & ~int_clr) | set;
      end
   end

   always @(negedge clk) begin
      if (running) begin
         check("R4 status.engine", status[0], m_eng);
         check("R4 eng_req", eng_req, m_eng);
         check("R4 eng_blocks", eng_blocks, m_blocks);
         check("R10 status.empty", status[1], mq.size() == 0);
         check("R5 status.mover", status[2], m_dma);
         check("R5 mv_req", mv_req, m_dma);
         check("R5 mv_to_ext", mv_to_ext, m_dir);
         check("R5 mv_words", mv_words, m_words);
         check("R5 mv_addr", mv_addr, m_maddr);
         check("R3 src_addr", src_addr, m_src);
         check("R6 tbl_load", tbl_load, m_tload);
         check("R6 tbl fields", {tbl_sel, tbl_internal, tbl_key, tbl_slot},
               {m_tsel, m_tint, m_tkey, m_tslot});
         check("R7 done flag", int_flags[0], m_int[0]);
         check("R8 badop flag", int_flags[1], m_int[1]);
         check("R2 overflow flag", int_flags[2], m_int[2]);
         check("R9 irq", irq, |m_int);
      end
      if (m_eng) begin eng_age++; eng_done = (eng_age >= eng_lat); end
      else begin eng_age = 0; eng_done = 0; end
      if (m_dma) begin mv_age++; mv_done = (mv_age >= mv_lat); end
      else begin mv_age = 0; mv_done = 0; end
   end

   function automatic logic [31:0] w_start(int n);
      return {6'h0E, 26'(n - 1)};
   endfunction
   function automatic logic [31:0] w_move(bit to_ext, logic [11:0] cnt);
      return {6'h22, to_ext, 1'b0, cnt, 12'h000};
   endfunction
   function automatic logic [31:0] w_table(logic [1:0] sel, bit intl, logic [2:0] slot);
      return {6'h15, sel, intl, 3'b001, slot, 17'h0};
   endfunction
   localparam logic [31:0] W_SET = {6'h10, 26'h0};
   localparam logic [31:0] W_END = {6'h11, 26'h0};

   task automatic push(logic [31:0] w);
      cmd_wr = 1; cmd_data = w;
      @(negedge clk);
      cmd_wr = 0;
   endtask
   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1 status", status, 3'b010);
      check("R1 flags", {int_flags, irq}, 4'h0);
      check("R1 requests", {eng_req, mv_req, tbl_load}, 3'b000);
      rst_n = 1;
      running = 1;
      idle(2);
      // R3 R4 R7: setup, start 4 blocks, complete
      push(W_SET); push(32'h8000_1000); push(w_start(4)); push(W_END);
      idle(20);
      // R5 R6: move in, table load waits for mover, complete
      push(w_move(1'b0, 12'd16)); push(32'h4000_0200);
      push(w_table(2'd3, 1'b1, 3'd5)); push(W_END);
      idle(25);
      // R8: unknown opcode then a one-block start
      push(32'hFC00_0000); push(w_start(1));
      idle(15);
      // R9: clear all
      int_clr = 3'b111; idle(1); int_clr = 3'b000;
      // R2: overflow while engine stalls the queue
      eng_lat = 40;
      push(w_start(16));
      push(w_start(2)); push(W_END); push(W_SET); push(32'h1234_5678);
      push(w_table(2'd1, 1'b0, 3'd2)); push(w_move(1'b1, 12'hFFF));
      push(32'h0BAD_0001); push(32'h9999_0000);
      idle(130);
      // R9: set wins over clear in the retire cycle
      int_clr = 3'b111; idle(1); int_clr = 3'b000;
      eng_lat = 4;
      int_clr = 3'b001;
      push(W_END);
      idle(5);
      int_clr = 3'b000;
      idle(3);
      // R2: write into a full queue in the cycle the head leaves
      int_clr = 3'b111; idle(1); int_clr = 3'b000;
      eng_lat = 30;
      push(w_start(1));
      push(w_start(3)); push(W_SET); push(32'hA5A5_0000);
      push(W_SET); push(32'h5A5A_0000);
      wait (eng_done == 1'b1);
      @(negedge clk);
      push(32'hDEAD_BEEF);
      idle(60);
      running = 0;
      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_err++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      finish_run();
   end
endmodule